// File: doc/BRIEF.md
# Byte-Wide Parallel Bus Target

This block is the target end of a narrow parallel link that a host processor drives. The host supplies a bus clock, an address-select line, a data-select line, a write-enable line and eight data lines shared in both directions. Each bus cycle moves one byte. The host launches its values on the rising edge of the bus clock, and the target samples them on the falling edge. Two address bytes form a 16-bit word address. A 32-bit word then moves as four data bytes. A write assembles the four bytes and commits them to an internal register or memory port. A read fetches the word from that port and returns it one byte per data cycle.

Consecutive words need no new address phase. After each fourth data byte the word address steps by one. In a read burst the target fetches the following word in the background while the current word is still being shifted out, so the host can read with no gap between words. The shared data lines appear here as a separate input, output and output-enable. The pad tristate sits at the chip edge.

Top module: `pbus_target`

## Requirements
- R1: While reset is asserted, memWr, memRd and busDataOe are low and busDataOut is zero. After reset, the first address byte is taken as the high address byte.
- R2: A byte is an address byte when busAddrSel is high at a falling edge. Two address bytes form the word address, high byte first. Address-select also returns the data byte count to zero.
- R3: A write is four data cycles (busDataSel high, busWrEn high), most significant byte first. On the falling edge that captures the fourth byte, memWr rises for exactly one cycle. During that cycle memAddr holds the word address and memWrData holds the assembled word.
- R4: On the falling edge that captures the second address byte, memRd rises for one cycle with memAddr equal to the new address. memRdData is sampled at the next falling edge.
- R5: In read data cycles (busDataSel high, busWrEn low), busDataOut carries the word most significant byte first, one byte per read cycle. The first read cycle comes at least two cycles after the last address byte.
- R6: busDataOe is high exactly when busDataSel is high, busWrEn is low and busAddrSel is low. In every other cycle it is low.
- R7: In a write burst, each group of four bytes after the first lands at the previous word address plus one.
- R8: In a read burst, the first byte of each word issues a one-cycle memRd at the word address plus one. Back-to-back read cycles then continue into the next word with no gap.
- R9: busAddrSel takes priority over busDataSel. An address byte in the middle of a word discards the partial word, and the next four data bytes form a whole word at the new address.
- R10: Cycles with both selects low change no state. Idle cycles may sit between the bytes of a word.
- R11: memWr and memRd are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| busClk | input | 1 | Bus clock from the host |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddrSel | input | 1 | The current byte is an address byte |
| busDataSel | input | 1 | The current byte is a data byte |
| busWrEn | input | 1 | 1 for a write data cycle, 0 for a read data cycle |
| busDataIn | input | 8 | Data lines as seen by the target |
| busDataOut | output | 8 | Byte the target drives during read cycles |
| busDataOe | output | 1 | Output enable for the shared data lines |
| memAddr | output | 16 | Word address of the internal access |
| memWrData | output | 32 | Word to write |
| memWr | output | 1 | One-cycle write strobe |
| memRd | output | 1 | One-cycle read strobe |
| memRdData | input | 32 | Read word, valid by the falling edge after memRd |

## Verification
The host inputs are driven 1 ns after each rising edge. A behavioural model updates at each falling edge, and the outputs are compared 2 ns after the rising edge. The strobes and memAddr are due one falling edge after the byte that causes them, so they are checked in the half-cycle that follows. busDataOe follows the inputs within the same cycle. The read byte must already be stable in the cycle the host samples it. The bench memory answers memRd at the next rising edge, so memRdData is settled before the falling edge that captures it. Stimulus always leaves at least one idle cycle between the last address byte and the first read cycle.

// File: rtl/pbus_target_pkg.sv
package pbus_target_pkg;

  // Per-edge commands from control to datapath.
  typedef struct packed {
    logic loadAddr;        // shift an address byte in
    logic addrDone;        // last address byte of the group
    logic wrByte;          // write data byte sampled
    logic commitWrite;     // fourth write byte sampled
    logic rdByte;          // read data byte consumed by host
    logic rdFirst;         // first byte of a read word (prefetch trigger)
    logic rdLast;          // last byte of a read word
    logic capture;         // memRdData is valid at this edge
    logic captureToShift;  // captured word goes straight to the output shifter
  } strobes_t;

endpackage

// File: rtl/pbus_target_ctrl.sv
module pbus_target_ctrl
  import pbus_target_pkg::*;
#(
  parameter int WORD_BYTES = 4,
  parameter int ADDR_BYTES = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     addrSel,
  input  logic     dataSel,
  input  logic     wrEn,
  output strobes_t stb,
  output logic     memWr,
  output logic     memRd
);
  localparam int CNT_W  = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1;
  localparam int AIDX_W = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;

  logic [CNT_W-1:0]  byteCnt;
  logic [AIDX_W-1:0] addrIdx;
  logic              toShiftQ;

  logic addrCyc, dataCyc, lastByte, addrLast;
  logic wrByte, rdByte;

  always_comb begin
    addrCyc  = addrSel;
    dataCyc  = dataSel & ~addrSel;
    lastByte = (byteCnt == CNT_W'(WORD_BYTES - 1));
    addrLast = (addrIdx == AIDX_W'(ADDR_BYTES - 1));
    wrByte   = dataCyc & wrEn;
    rdByte   = dataCyc & ~wrEn;

    stb.loadAddr       = addrCyc;
    stb.addrDone       = addrCyc & addrLast;
    stb.wrByte         = wrByte;
    stb.commitWrite    = wrByte & lastByte;
    stb.rdByte         = rdByte;
    stb.rdFirst        = rdByte & (byteCnt == '0);
    stb.rdLast         = rdByte & lastByte;
    stb.capture        = memRd;
    stb.captureToShift = toShiftQ;
  end

  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) begin
      byteCnt  <= '0;
      addrIdx  <= '0;
      memWr    <= 1'b0;
      memRd    <= 1'b0;
      toShiftQ <= 1'b0;
    end else begin
      if (addrCyc) begin
        addrIdx <= addrLast ? '0 : addrIdx + 1'b1;
        byteCnt <= '0;
      end else if (dataCyc) begin
        byteCnt <= byteCnt + 1'b1;
      end
      memWr    <= wrByte & lastByte;
      memRd    <= (addrCyc & addrLast) | (rdByte & (byteCnt == '0));
      toShiftQ <= addrCyc & addrLast;
    end
  end

  // An idle bus cycle leaves the byte position untouched.
  assert_idle_keeps_count_R10: assert property (@(negedge clk) disable iff (!rstN)
    (!addrSel && !dataSel) |=> $stable(byteCnt));

  // The write strobe never lasts beyond one cycle.
  assert_write_pulse_R3: assert property (@(negedge clk) disable iff (!rstN)
    memWr |=> !memWr);

  // Read and write strobes are exclusive.
  assert_strobe_exclusive_R11: assert property (@(negedge clk) disable iff (!rstN)
    !(memWr && memRd));

endmodule

// File: rtl/pbus_target_dp.sv
module pbus_target_dp
  import pbus_target_pkg::*;
#(
  parameter int BYTE_W     = 8,
  parameter int ADDR_W     = 16,
  parameter int WORD_BYTES = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  strobes_t                      stb,
  input  logic [BYTE_W-1:0]             din,
  input  logic [BYTE_W*WORD_BYTES-1:0]  memRdData,
  output logic [BYTE_W-1:0]             dout,
  output logic [ADDR_W-1:0]             memAddr,
  output logic [BYTE_W*WORD_BYTES-1:0]  memWrData
);
  localparam int WORD_W = BYTE_W * WORD_BYTES;
  localparam int ACC_W  = WORD_W - BYTE_W;

  logic [ADDR_W-1:0] wordAddr;
  logic [ADDR_W-1:0] assembled;
  logic [ACC_W-1:0]  wrAcc;
  logic [WORD_W-1:0] rdShift;
  logic [WORD_W-1:0] nextWord;

  assign assembled = {wordAddr[ADDR_W-BYTE_W-1:0], din};
  assign dout      = rdShift[WORD_W-1 -: BYTE_W];

  // Word address: loaded byte by byte, stepped at the end of each word.
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) begin
      wordAddr <= '0;
    end else if (stb.loadAddr) begin
      wordAddr <= assembled;
    end else if (stb.commitWrite || stb.rdLast) begin
      wordAddr <= wordAddr + 1'b1;
    end
  end

  // Address presented with each internal strobe.
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) begin
      memAddr <= '0;
    end else if (stb.addrDone) begin
      memAddr <= assembled;
    end else if (stb.commitWrite) begin
      memAddr <= wordAddr;
    end else if (stb.rdFirst) begin
      memAddr <= wordAddr + 1'b1;
    end
  end

  // Write assembly, most significant byte first.
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) begin
      wrAcc     <= '0;
      memWrData <= '0;
    end else begin
      if (stb.wrByte)      wrAcc     <= (wrAcc << BYTE_W) | ACC_W'(din);
      if (stb.commitWrite) memWrData <= {wrAcc, din};
    end
  end

  // Read side: output shifter plus one prefetched word.
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) begin
      rdShift  <= '0;
      nextWord <= '0;
    end else begin
      if (stb.capture && stb.captureToShift) begin
        rdShift <= memRdData;
      end else if (stb.rdLast) begin
        rdShift <= nextWord;
      end else if (stb.rdByte) begin
        rdShift <= rdShift << BYTE_W;
      end
      if (stb.capture && !stb.captureToShift) nextWord <= memRdData;
    end
  end

  // A fresh read result and a host byte never meet on one edge.
  assert_no_early_read_R5: assert property (@(negedge clk) disable iff (!rstN)
    (stb.capture && stb.captureToShift) |-> !stb.rdByte);

endmodule

// File: rtl/pbus_target.sv
module pbus_target #(
  parameter int BYTE_W     = 8,
  parameter int ADDR_W     = 16,
  parameter int WORD_BYTES = 4
) (
  input  logic                         busClk,
  input  logic                         rstN,
  input  logic                         busAddrSel,
  input  logic                         busDataSel,
  input  logic                         busWrEn,
  input  logic [BYTE_W-1:0]            busDataIn,
  output logic [BYTE_W-1:0]            busDataOut,
  output logic                         busDataOe,
  output logic [ADDR_W-1:0]            memAddr,
  output logic [BYTE_W*WORD_BYTES-1:0] memWrData,
  output logic                         memWr,
  output logic                         memRd,
  input  logic [BYTE_W*WORD_BYTES-1:0] memRdData
);
  localparam int ADDR_BYTES = ADDR_W / BYTE_W;

  pbus_target_pkg::strobes_t stb;

  assign busDataOe = busDataSel & ~busWrEn & ~busAddrSel;

  pbus_target_ctrl #(
    .WORD_BYTES(WORD_BYTES),
    .ADDR_BYTES(ADDR_BYTES)
  ) uCtrl (
    .clk    (busClk),
    .rstN   (rstN),
    .addrSel(busAddrSel),
    .dataSel(busDataSel),
    .wrEn   (busWrEn),
    .stb    (stb),
    .memWr  (memWr),
    .memRd  (memRd)
  );

  pbus_target_dp #(
    .BYTE_W    (BYTE_W),
    .ADDR_W    (ADDR_W),
    .WORD_BYTES(WORD_BYTES)
  ) uDp (
    .clk      (busClk),
    .rstN     (rstN),
    .stb      (stb),
    .din      (busDataIn),
    .memRdData(memRdData),
    .dout     (busDataOut),
    .memAddr  (memAddr),
    .memWrData(memWrData)
  );

  // A write strobe always follows a sampled write data byte.
  assert_write_source_R3: assert property (@(negedge busClk) disable iff (!rstN)
    memWr |-> $past(busDataSel && busWrEn && !busAddrSel));

  // A read strobe follows an address byte or a read data byte.
  assert_read_source_R4: assert property (@(negedge busClk) disable iff (!rstN)
    memRd |-> $past(busAddrSel || (busDataSel && !busWrEn)));

  // The target never drives while the host sends an address.
  assert_release_on_address_R6: assert property (@(negedge busClk) disable iff (!rstN)
    busAddrSel |-> !busDataOe);

endmodule

// File: tb/tb_pbus_target.sv
`timescale 1ns/100ps
module tb_pbus_target;
  logic        clk = 1'b0;
  logic        rstN;
  logic        addrSel, dataSel, wrEn;
  logic [7:0]  din;
  logic [7:0]  busDataOut;
  logic        busDataOe;
  logic [15:0] memAddr;
  logic [31:0] memWrData;
  logic        memWr, memRd;
  logic [31:0] memRdData;

  always #2.5 clk = ~clk;

  pbus_target dut (
    .busClk(clk), .rstN(rstN), .busAddrSel(addrSel), .busDataSel(dataSel),
    .busWrEn(wrEn), .busDataIn(din), .busDataOut(busDataOut), .busDataOe(busDataOe),
    .memAddr(memAddr), .memWrData(memWrData), .memWr(memWr), .memRd(memRd),
    .memRdData(memRdData)
  );

  int vectors = 0;
  int fails   = 0;
  string phase = "reset";

  function automatic logic [31:0] initWord(input int a);
    return {a[15:0], ~a[15:0]};
  endfunction

  // Memory seen by the design: one-cycle registered read.
  logic [31:0] dutMem[int];
  always @(posedge clk) begin
    if (memWr) dutMem[int'(memAddr)] = memWrData;
    if (memRd) memRdData <= dutMem.exists(int'(memAddr)) ? dutMem[int'(memAddr)]
                                                         : initWord(int'(memAddr));
  end

  // Behavioural reference model.
  logic [31:0] modelMem[int];
  logic [7:0]  aQ[$];
  logic [7:0]  wQ[$];
  logic [7:0]  oQ[$];
  int          mAddr, cnt;
  bit          expWr, expRd;
  logic [15:0] expAddr;
  logic [31:0] expWd;

  function automatic logic [31:0] modelRead(input int a);
    return modelMem.exists(a) ? modelMem[a] : initWord(a);
  endfunction

  task automatic loadOut(input int a);
    logic [31:0] w;
    w = modelRead(a);
    oQ.delete();
    for (int i = 3; i >= 0; i--) oQ.push_back(w[i*8 +: 8]);
  endtask

  always @(negedge clk) begin
    expWr = 0;
    expRd = 0;
    if (!rstN) begin
      aQ.delete(); wQ.delete(); oQ.delete();
      mAddr = 0; cnt = 0;
    end else if (addrSel) begin
      cnt = 0;
      wQ.delete();
      aQ.push_back(din);
      if (aQ.size() == 2) begin
        mAddr = {aQ[0], aQ[1]};
        aQ.delete();
        expRd = 1; expAddr = mAddr[15:0];
        loadOut(mAddr);
      end
    end else if (dataSel && wrEn) begin
      wQ.push_back(din);
      cnt++;
      if (cnt == 4) begin
        expWr = 1; expAddr = mAddr[15:0];
        expWd = {wQ[0], wQ[1], wQ[2], wQ[3]};
        modelMem[mAddr] = expWd;
        wQ.delete();
        cnt = 0;
        mAddr = (mAddr + 1) & 16'hFFFF;
      end
    end else if (dataSel) begin
      if (cnt == 0) begin
        expRd = 1; expAddr = 16'((mAddr + 1) & 16'hFFFF);
      end
      if (oQ.size() > 0) void'(oQ.pop_front());
      cnt++;
      if (cnt == 4) begin
        cnt = 0;
        mAddr = (mAddr + 1) & 16'hFFFF;
        loadOut(mAddr);
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s (%s) at %0t: actual %h expected %h", req, phase, $time, act, exp);
    end
  endtask

  // Per-cycle comparison, away from both edges.
  always @(posedge clk) begin
    #2;
    if (rstN) begin
      check(memWr == expWr, "R3/R7 write strobe", 32'(memWr), 32'(expWr));
      check(memRd == expRd, "R4/R8 read strobe", 32'(memRd), 32'(expRd));
      check(!(memWr && memRd), "R11 exclusive strobes", {memWr, memRd}, 0);
      if (expWr) begin
        check(memAddr == expAddr, "R2/R7 write address", 32'(memAddr), 32'(expAddr));
        check(memWrData == expWd, "R3 write data", memWrData, expWd);
      end
      if (expRd)
        check(memAddr == expAddr, "R4/R8 read address", 32'(memAddr), 32'(expAddr));
      check(busDataOe == (dataSel && !wrEn && !addrSel), "R6 output enable",
            32'(busDataOe), 32'(dataSel && !wrEn && !addrSel));
      if (dataSel && !wrEn && !addrSel && oQ.size() > 0)
        check(busDataOut == oQ[0], "R5 read byte", 32'(busDataOut), 32'(oQ[0]));
    end
  end

  task automatic cyc(input bit a, input bit d, input bit w, input logic [7:0] b);
    @(posedge clk);
    #1;
    addrSel = a; dataSel = d; wrEn = w; din = b;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 8'h00);
  endtask

  task automatic sendAddr(input logic [15:0] a);
    cyc(1, 0, 0, a[15:8]);
    cyc(1, 0, 0, a[7:0]);
  endtask

  task automatic wrWord(input logic [31:0] w, input int gap);
    for (int i = 3; i >= 0; i--) begin
      cyc(0, 1, 1, w[i*8 +: 8]);
      if (gap > 0) idle(gap);
    end
  endtask

  task automatic rdBytes(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      cyc(0, 1, 0, 8'h00);
      if (gap > 0) idle(gap);
    end
  endtask

  bit timedOut = 0;

  initial begin
    rstN = 0; addrSel = 0; dataSel = 0; wrEn = 0; din = 0; memRdData = 0;
    repeat (3) @(posedge clk);
    #2;
    check(!memWr && !memRd, "R1 strobes in reset", {memWr, memRd}, 0);
    check(!busDataOe, "R1 enable in reset", 32'(busDataOe), 0);
    check(busDataOut == 8'h00, "R1 output byte in reset", 32'(busDataOut), 0);
    @(posedge clk); #1 rstN = 1;

    fork
      begin
        phase = "R2 R3 single write";
        sendAddr(16'h1545); wrWord(32'hDEADBEEF, 0); idle(2);
        phase = "R4 R5 single read";
        sendAddr(16'h1545); idle(1); rdBytes(4, 0); idle(2);
        phase = "R7 write burst";
        sendAddr(16'h0102);
        wrWord(32'hDEADBEEF, 0); wrWord(32'hCAFEBABE, 0); wrWord(32'hFEEDBEBE, 0);
        idle(2);
        phase = "R8 read burst";
        sendAddr(16'h0101); idle(1); rdBytes(16, 0); idle(2);
        phase = "R10 gapped write and read";
        sendAddr(16'h2000); wrWord(32'h01234567, 2); idle(1);
        sendAddr(16'h1FFF); idle(2); rdBytes(8, 1); idle(2);
        phase = "R9 abort mid word";
        sendAddr(16'h3000); cyc(0, 1, 1, 8'hAA); cyc(0, 1, 1, 8'hBB);
        sendAddr(16'h3005); wrWord(32'h89ABCDEF, 0); idle(1);
        sendAddr(16'h3005); idle(1); rdBytes(4, 0); idle(1);
        phase = "R9 both selects high";
        cyc(1, 1, 0, 8'h00); cyc(1, 1, 0, 8'h42); idle(1); rdBytes(4, 0); idle(1);
        phase = "R2 wrap at top of space";
        sendAddr(16'hFFFF); wrWord(32'h0BADF00D, 0); wrWord(32'h600DCAFE, 0); idle(1);
        sendAddr(16'h0000); idle(1); rdBytes(4, 0); idle(3);
      end
      begin
        repeat (100000) @(posedge clk);
        timedOut = 1;
      end
    join_any
    disable fork;
    if (timedOut) begin
      vectors++; fails++;
      $display("FAIL watchdog (%s): actual timeout expected completion", phase);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule